// File: doc/BRIEF.md
# Soft-Ramped Volume Stage with Soft Mute

This block scales one stream of signed audio samples by a programmable volume. The volume is set by an 8-bit code in half-decibel steps, code zero meaning silence. A new code never takes effect at once. An internal fine level walks toward the level the code asks for, one step per sample, so the gain moves in very small steps. Each code step spans `STEPS_PER_CODE` fine levels.

A separate soft-mute request drives a second, linear ramp. This ramp fades the output to silence over `2^MUTE_LOG2` samples and brings it back at the same rate. When the request is released part way, the ramp reverses from where it stands. The two ramps run independently and their factors multiply. A power-down input returns the block to its reset state and ignores samples. A run input, while low, pins the volume at 0 dB; when it rises again, the volume fades toward the programmed code. Several channels are built by instantiating the block several times.

Top module: `soft_volume`

## Requirements
- R1: After reset, out_valid and out_data are 0, the fine level is at full scale (`FULL = 2^CODE_W * STEPS_PER_CODE`, i.e. 0 dB) and the mute factor is at unity (`2^MUTE_LOG2`). The first sample then passes unchanged.
- R2: Each accepted in_valid strobe produces exactly one out_valid pulse on the next clock, carrying the result for that sample. No pulse appears without a strobe.
- R3: The target level is 0 for code 0x00 and `(code+1)*STEPS_PER_CODE` otherwise, so 0xFF is 0 dB and each code step is 0.5 dB. On each strobe the level moves one step toward the target. Without a strobe it holds. Each sample is scaled with the level in force before that sample's step.
- R4: Gain law: `a = FULL - level`, `k = a / (12*STEPS_PER_CODE)`, `r = a % (12*STEPS_PER_CODE)`, `mant = 2^GAIN_FRAC - floor(r*2^(GAIN_FRAC-1) / (12*STEPS_PER_CODE))`, `gain = mant >> k`. Level 0 gives a gain of 0, and every 12 codes halve the gain exactly.
- R5: On each strobe the mute factor steps down by one while mute_req is high and up by one while it is low, within the range 0 to `2^MUTE_LOG2`. A full fade therefore takes `2^MUTE_LOG2` samples each way, and a factor of 0 gives an output of 0.
- R6: Releasing mute_req part way through a fade reverses the ramp from its present factor. No jump occurs.
- R7: `out = sat(floor((x*gain*mute + 2^(SH-1)) / 2^SH))`, with `SH = GAIN_FRAC + MUTE_LOG2`. The rounding is half up and the result saturates to the signed DATA_W range.
- R8: While run is low, the level is forced to FULL on every clock. After run rises, the level ramps from FULL toward the target.
- R9: The mute ramp and the volume ramp step independently and both apply to the same sample.
- R10: While pd is high, strobes are ignored and out_valid stays low. The level and mute factor are held at their reset values.
- R11: A change from code 0xFF to 0x00 takes exactly FULL strobes. On the way back, the sample taken at level FULL-1 is below unity gain and the next sample is exact unity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pd | input | 1 | Power-down: clears state, ignores samples |
| run | input | 1 | Low holds volume at 0 dB |
| mute_req | input | 1 | Soft-mute request |
| atten_code | input | CODE_W | Volume code, 0xFF = 0 dB, 0x00 = silence |
| in_valid | input | 1 | Sample strobe |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| out_data | output | DATA_W | Signed scaled sample |

## Verification
The bench builds the block with `STEPS_PER_CODE = 3` and `MUTE_LOG2 = 5`. A full volume sweep then lasts 768 samples and a mute fade lasts 32, so complete floor-to-ceiling ramps, mid-fade reversals and run/power-down recovery all fit in a short run. At these values an octave is 36 levels. That puts exact halving points, the half-up rounding of odd values at half gain, and the last fine level below unity within a few dozen strobes. Every output is compared against a model built from the gain law and the stepping rules.

// File: rtl/soft_volume.sv
`timescale 1ns/1ps
module soft_volume #(
  parameter int DATA_W         = 24,
  parameter int CODE_W         = 8,
  parameter int STEPS_PER_CODE = 29,
  parameter int MUTE_LOG2      = 10,
  parameter int GAIN_FRAC      = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pd,
  input  logic                     run,
  input  logic                     mute_req,
  input  logic [CODE_W-1:0]        atten_code,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_data
);
  localparam int FULL     = (1 << CODE_W) * STEPS_PER_CODE;
  localparam int LVL_W    = $clog2(FULL + 1);
  localparam int OCT      = 12 * STEPS_PER_CODE;
  localparam int MUTE_LEN = 1 << MUTE_LOG2;
  localparam int MF_W     = MUTE_LOG2 + 1;
  localparam int SH       = GAIN_FRAC + MUTE_LOG2;
  localparam int PW       = DATA_W + GAIN_FRAC + MF_W + 3;
  localparam logic signed [PW-1:0] HALF = PW'(64'd1 << (SH - 1));
  localparam logic signed [PW-1:0] MAXV = PW'((64'd1 << (DATA_W - 1)) - 64'd1);
  localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

  logic [LVL_W-1:0]     lvl, tgt, att, oct_idx, oct_rem;
  logic [MF_W-1:0]      mfac;
  logic [31:0]          slope;
  logic [GAIN_FRAC:0]   mant, vgain;
  logic signed [PW-1:0] prod, scaled;
  logic signed [DATA_W-1:0] sat;

  assign tgt     = (atten_code == '0) ? '0
                 : LVL_W'((32'(atten_code) + 32'd1) * 32'(STEPS_PER_CODE));
  assign att     = LVL_W'(FULL) - lvl;
  assign oct_idx = att / LVL_W'(OCT);
  assign oct_rem = att % LVL_W'(OCT);
  assign slope   = (32'(oct_rem) << (GAIN_FRAC - 1)) / 32'(OCT);
  assign mant    = (GAIN_FRAC+1)'((32'd1 << GAIN_FRAC) - slope);
  assign vgain   = (lvl == '0) ? '0 : (mant >> oct_idx);

  assign prod    = PW'(in_data) * PW'($signed({1'b0, vgain})) * PW'($signed({1'b0, mfac}));
  assign scaled  = (prod + HALF) >>> SH;
  assign sat     = (scaled > MAXV) ? {1'b0, {(DATA_W-1){1'b1}}}
                 : (scaled < MINV) ? {1'b1, {(DATA_W-1){1'b0}}}
                 : scaled[DATA_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl       <= LVL_W'(FULL);
      mfac      <= MF_W'(MUTE_LEN);
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (pd) begin
      lvl       <= LVL_W'(FULL);
      mfac      <= MF_W'(MUTE_LEN);
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= sat;
      if (!run) lvl <= LVL_W'(FULL);
      else if (in_valid) begin
        if (lvl < tgt)      lvl <= lvl + 1'b1;
        else if (lvl > tgt) lvl <= lvl - 1'b1;
      end
      if (in_valid) begin
        if (mute_req) begin
          if (mfac != '0) mfac <= mfac - 1'b1;
        end else if (mfac != MF_W'(MUTE_LEN)) mfac <= mfac + 1'b1;
      end
    end
  end
endmodule

// File: rtl/soft_volume_sva.sv
`timescale 1ns/1ps
module soft_volume_sva #(
  parameter int DATA_W   = 24,
  parameter int LVL_W    = 13,
  parameter int FULL     = 7424,
  parameter int MF_W     = 11,
  parameter int MUTE_LEN = 1024
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     pd,
  input logic                     run,
  input logic                     in_valid,
  input logic                     out_valid,
  input logic signed [DATA_W-1:0] out_data,
  input logic [LVL_W-1:0]         lvl,
  input logic [MF_W-1:0]          mfac
);
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !pd) |=> out_valid);
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid || pd) |=> !out_valid);
  p_level_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && run && !pd) |=>
      (lvl == $past(lvl) || lvl == $past(lvl) + 1'b1 || lvl == $past(lvl) - 1'b1));
  p_level_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && run && !pd) |=> $stable(lvl));
  p_zero_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !pd && lvl == '0) |=> out_data == '0);
  p_mute_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mfac <= MF_W'(MUTE_LEN));
  p_mute_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !pd) |=>
      (mfac == $past(mfac) + 1'b1 || mfac == $past(mfac) - 1'b1 || mfac == $past(mfac)));
  p_mute_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !pd) |=> $stable(mfac));
  p_mute_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !pd && mfac == '0) |=> out_data == '0);
  p_run_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !pd) |=> lvl == LVL_W'(FULL));
  p_pd_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> (!out_valid && lvl == LVL_W'(FULL) && mfac == MF_W'(MUTE_LEN)));
endmodule

bind soft_volume soft_volume_sva #(
  .DATA_W(DATA_W), .LVL_W(LVL_W), .FULL(FULL), .MF_W(MF_W), .MUTE_LEN(MUTE_LEN)
) u_sva (
  .clk(clk), .rst_n(rst_n), .pd(pd), .run(run), .in_valid(in_valid),
  .out_valid(out_valid), .out_data(out_data), .lvl(lvl), .mfac(mfac)
);

// File: tb/soft_volume_test.sv
`timescale 1ns/1ps
module soft_volume_test;
  localparam int DW = 24, CW = 8, STEPS = 3, MLOG = 5, GF = 16;
  localparam longint FULL = (1 << CW) * STEPS;
  localparam longint OCT  = 12 * STEPS;
  localparam longint MLEN = 1 << MLOG;
  localparam int     SH   = GF + MLOG;
  localparam longint XMAX = (64'sd1 << (DW-1)) - 1;
  localparam longint XMIN = -(64'sd1 << (DW-1));

  logic clk = 0, rst_n = 0, pd = 0, run = 1, mute_req = 0, in_valid = 0;
  logic [CW-1:0] atten_code = 8'hFF;
  logic signed [DW-1:0] in_data = '0;
  logic out_valid;
  logic signed [DW-1:0] out_data;

  soft_volume #(.DATA_W(DW), .CODE_W(CW), .STEPS_PER_CODE(STEPS), .MUTE_LOG2(MLOG), .GAIN_FRAC(GF)) uut (
    .clk(clk), .rst_n(rst_n), .pd(pd), .run(run), .mute_req(mute_req), .atten_code(atten_code),
    .in_valid(in_valid), .in_data(in_data), .out_valid(out_valid), .out_data(out_data));

  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  longint q_exp[$];
  string  q_tag[$];
  longint mL = FULL, mM = MLEN;

  function automatic longint gain_of(longint lv);
    longint a, k, r, mant;
    if (lv == 0) return 0;
    a = FULL - lv; k = a / OCT; r = a % OCT;
    mant = (64'sd1 << GF) - ((r << (GF-1)) / OCT);
    return (k > 40) ? 0 : (mant >> k);
  endfunction

  function automatic longint expect_of(longint x, longint lv, longint m);
    longint p, s;
    p = x * gain_of(lv) * m;
    s = (p + (64'sd1 << (SH-1))) >>> SH;
    if (s > XMAX) s = XMAX;
    if (s < XMIN) s = XMIN;
    return s;
  endfunction

  function automatic longint target_of(logic [CW-1:0] c);
    return (c == 0) ? 0 : (longint'(c) + 1) * STEPS;
  endfunction

  task automatic check(input bit ok, input string req, input longint got, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic strobe(input longint x, input string tag, output longint got);
    @(negedge clk);
    in_valid = 1; in_data = x[DW-1:0];
    if (!pd) begin
      q_exp.push_back(expect_of(x, mL, mM));
      q_tag.push_back(tag);
      if (run) begin
        if (mL < target_of(atten_code)) mL++;
        else if (mL > target_of(atten_code)) mL--;
      end
      if (mute_req) begin if (mM > 0) mM--; end
      else if (mM < MLEN) mM++;
    end
    @(posedge clk); #1;
    in_valid = 0;
    got = longint'(out_data);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_exp.size() == 0) check(0, "R2 unexpected output", longint'(out_data), 0);
      else begin
        longint e; string t;
        e = q_exp.pop_front(); t = q_tag.pop_front();
        check(longint'(out_data) == e, t, longint'(out_data), e);
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    longint g, prev;
    idle(3);
    check(out_valid == 0, "R1 reset out_valid", longint'(out_valid), 0);
    check(out_data == 0, "R1 reset out_data", longint'(out_data), 0);
    rst_n = 1; idle(2);

    strobe(1234567, "R1", g);
    check(g == 1234567, "R1 unity after reset", g, 1234567);
    foreach (q_exp[i]) ;
    begin
      longint pat[6] = '{0, 1, -1, XMAX, XMIN, -7654321};
      foreach (pat[i]) begin
        strobe(pat[i], "R7", g);
        check(g == pat[i], "R7 unity passthrough", g, pat[i]);
      end
    end
    idle(2);
    check(out_valid == 0, "R2 no output without strobe", longint'(out_valid), 0);

    atten_code = 8'hFE;
    for (int i = 0; i < 6; i++) strobe(1000000, "R3", g);
    atten_code = 8'hF3;
    idle(20);
    for (int i = 0; i < 40; i++) strobe(1000000, "R3", g);
    strobe(1000000, "R4", g); check(g == 500000, "R4 octave halves", g, 500000);
    strobe(3, "R7", g);  check(g == 2, "R7 round half up positive", g, 2);
    strobe(-3, "R7", g); check(g == -1, "R7 round half up negative", g, -1);
    strobe(XMIN, "R4", g); check(g == XMIN / 2, "R4 octave negative", g, XMIN / 2);

    atten_code = 8'hFF;
    for (int i = 0; i < 40; i++) strobe(2000000, "R3", g);
    mute_req = 1;
    for (int i = 0; i < 40; i++) strobe(2000000, "R5", g);
    check(g == 0, "R5 muted silent", g, 0);
    mute_req = 0;
    for (int i = 0; i < 40; i++) strobe(2000000, "R5", g);
    check(g == 2000000, "R5 unmuted unity", g, 2000000);

    mute_req = 1;
    for (int i = 0; i < 10; i++) strobe(-4000000, "R6", g);
    mute_req = 0;
    for (int i = 0; i < 10; i++) strobe(-4000000, "R6", prev);
    check(prev != -4000000, "R6 still below unity", prev, -4000000);
    strobe(-4000000, "R6", g);
    check(g == -4000000, "R6 reversed to unity", g, -4000000);

    atten_code = 8'hF9; mute_req = 1;
    for (int i = 0; i < 45; i++) strobe(3000000, "R9", g);
    check(g == 0, "R9 mute wins at factor 0", g, 0);
    mute_req = 0;
    for (int i = 0; i < 45; i++) strobe(3000000, "R9", g);
    check(g == expect_of(3000000, target_of(8'hF9), MLEN), "R9 volume settled", g,
          expect_of(3000000, target_of(8'hF9), MLEN));

    atten_code = 8'h80;
    for (int i = 0; i < 50; i++) strobe(500000, "R8", g);
    run = 0; mL = FULL; idle(2);
    strobe(500000, "R8", g); check(g == 500000, "R8 held at 0dB", g, 500000);
    run = 1;
    for (int i = 0; i < 20; i++) strobe(500000, "R8", g);
    check(g < 500000, "R8 fades after release", g, 500000);

    mute_req = 1;
    for (int i = 0; i < 5; i++) strobe(500000, "R10", g);
    pd = 1; mL = FULL; mM = MLEN; idle(2);
    for (int i = 0; i < 5; i++) begin
      strobe(777, "R10", g);
      check(out_valid == 0, "R10 ignored in power-down", longint'(out_valid), 0);
    end
    pd = 0; mute_req = 0;
    strobe(600000, "R10", g);
    check(g == 600000, "R10 state back to reset", g, 600000);

    atten_code = 8'h00;
    for (longint i = 0; i <= FULL; i++) strobe(XMAX, "R11", g);
    check(g == 0, "R11 reaches silence", g, 0);
    atten_code = 8'hFF;
    for (longint i = 0; i < FULL; i++) strobe(XMAX, "R11", prev);
    check(prev != XMAX, "R11 below unity one level short", prev, XMAX);
    strobe(XMAX, "R11", g);
    check(g == XMAX, "R11 unity after full ramp", g, XMAX);

    idle(4);
    check(q_exp.size() == 0, "R2 every strobe answered", q_exp.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule